// File: doc/BRIEF.md
# Flash Write-Buffer Program Sequencer

This block sits behind the decoded bus-write path of a NOR-style flash controller. It recognises the buffered-program command sequence and gathers a page of data words. The sequence has two unlock writes, the buffer command, a word-count write, one write per data word and a closing confirm write. Once the confirm is seen it raises a program request toward the memory model. It keeps the gathered page, the first data address and the number of loaded words steady on its outputs until the model acknowledges.

When the host has already placed the controller in unlock-bypass mode, the buffer command is taken straight from idle and the two unlock writes are skipped. The sequence aborts when a data address leaves the page, when the count is too large, or when more data words arrive than the count allows. An abort raises a sticky flag and throws the gathered words away. After each completed program or abort the sequencer is back in idle, ready for a new command.

Top module: `wbuf_prog_seq`

## Requirements
- R1: After reset `busy`, `prog_req`, `done` and `abort` are 0, `word_cnt` is 0 and every buffer slot reads back with `rd_valid` = 0.
- R2: Without bypass, the accepted sequence is: a write with address bits [11:0] = 0x555 and data low byte 0xAA, then [11:0] = 0x2AA with 0x55, then low byte 0x25 (buffer command, any address), then the count write, then the data writes, then low byte 0x29 (confirm). `prog_req` is 0 before the confirm and 1 after the clock edge that samples it. A full page is therefore 37 writes.
- R3: The count write carries, in data bits [7:0], the number of data words minus one. After loading, `word_cnt` equals that value plus one, and `start_addr` equals the address of the first data write.
- R4: Each data write stores all 16 data bits in slot address[4:0]. `rd_data`/`rd_valid` at `rd_idx` show the stored word and 1 for written slots, and `rd_valid` = 0 for the other slots.
- R5: A data write whose address bits above bit 4 differ from those of `start_addr` sets `abort`, returns to idle, forces `word_cnt` to 0 and clears every `rd_valid`.
- R6: A count value above 31 sets `abort` and returns to idle without loading.
- R7: After the last counted data word, a write whose low byte is not 0x29 is an excess data word: it sets `abort`, clears the buffer and raises no request.
- R8: `prog_req` and `busy` stay 1 until `prog_ack`. Writes in that time change neither `word_cnt` nor the buffer. The edge that samples `prog_ack` drops both and sets `done`.
- R9: With `bypass_en` = 1, a low byte 0x25 written in idle starts the sequence directly. A full page then takes 35 writes.
- R10: Data bits [15:8] and address bits above [11:0] are ignored in unlock, command, count and confirm writes. In data writes they are used.
- R11: A wrong unlock write returns to idle without raising `abort`, and the writes that follow it start no program. `done` and `abort` are cleared when the next buffer command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | Unlock-bypass mode active: unlock writes are skipped |
| wr_en | input | 1 | Decoded bus write cycle |
| wr_addr | input | AW (24) | Write address |
| wr_data | input | 16 | Write data |
| prog_ack | input | 1 | Memory model has finished programming the page |
| rd_idx | input | 5 | Buffer slot to view |
| prog_req | output | 1 | Page program request, held until acknowledged |
| busy | output | 1 | A sequence or a program is in progress |
| done | output | 1 | Last program completed (sticky) |
| abort | output | 1 | Last sequence aborted (sticky) |
| start_addr | output | AW (24) | Address of the first data word |
| word_cnt | output | 6 | Number of valid words loaded |
| rd_data | output | 16 | Buffer word at `rd_idx` |
| rd_valid | output | 1 | Slot at `rd_idx` holds a loaded word |

## Verification
Each write updates state, `word_cnt`, `prog_req` and the flags on the clock edge that samples it. The bench drives every write at a falling edge and reads the results at the next falling edge, one edge later. `rd_data` and `rd_valid` are combinational from `rd_idx` and the registered buffer, so the bench reads them 1 ns after it changes the index. The bench samples `prog_req` both just before and just after the confirm edge, which pins the request to exactly that write. For every loaded count from 1 to 32 the expected slot contents are computed arithmetically from the page offset.

// File: rtl/wbuf_prog_seq.sv
module wbuf_prog_seq #(
  parameter int AW = 24,
  parameter int PAGE_WORDS = 32,
  parameter int CMD_AW = 12,
  parameter logic [CMD_AW-1:0] UNL_ADDR1 = 12'h555,
  parameter logic [CMD_AW-1:0] UNL_ADDR2 = 12'h2AA,
  parameter logic [7:0] UNL_DATA1 = 8'hAA,
  parameter logic [7:0] UNL_DATA2 = 8'h55,
  parameter logic [7:0] BUF_CMD = 8'h25,
  parameter logic [7:0] CONFIRM = 8'h29
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bypass_en,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [15:0]           wr_data,
  input  logic                  prog_ack,
  input  logic [$clog2(PAGE_WORDS)-1:0] rd_idx,
  output logic                  prog_req,
  output logic                  busy,
  output logic                  done,
  output logic                  abort,
  output logic [AW-1:0]         start_addr,
  output logic [$clog2(PAGE_WORDS):0] word_cnt,
  output logic [15:0]           rd_data,
  output logic                  rd_valid
);
  localparam int PW = $clog2(PAGE_WORDS);
  localparam logic [7:0] MAX_CNT = 8'(PAGE_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_UNL2, S_CMD, S_CNT, S_LOAD, S_CONF, S_PROG} st_t;

  st_t                   state;
  logic [PW-1:0]         remain;
  logic [PAGE_WORDS-1:0] vmask;
  logic [15:0]           mem [PAGE_WORDS];

  wire [7:0]        lo      = wr_data[7:0];
  wire [CMD_AW-1:0] ca      = wr_addr[CMD_AW-1:0];
  wire [PW-1:0]     slot    = wr_addr[PW-1:0];
  wire              first   = (word_cnt == '0);
  wire              in_page = first || (wr_addr[AW-1:PW] == start_addr[AW-1:PW]);
  wire              ld_ok   = (state == S_LOAD) && wr_en && in_page;

  assign prog_req = (state == S_PROG);
  assign busy     = (state != S_IDLE);
  assign rd_data  = mem[rd_idx];
  assign rd_valid = vmask[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      remain     <= '0;
      vmask      <= '0;
      word_cnt   <= '0;
      start_addr <= '0;
      done       <= 1'b0;
      abort      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (wr_en) begin
          if (bypass_en && lo == BUF_CMD) begin
            state    <= S_CNT;
            done     <= 1'b0;
            abort    <= 1'b0;
            word_cnt <= '0;
            vmask    <= '0;
          end else if (!bypass_en && ca == UNL_ADDR1 && lo == UNL_DATA1) begin
            state <= S_UNL2;
          end
        end
        S_UNL2: if (wr_en) state <= (ca == UNL_ADDR2 && lo == UNL_DATA2) ? S_CMD : S_IDLE;
        S_CMD: if (wr_en) begin
          if (lo == BUF_CMD) begin
            state    <= S_CNT;
            done     <= 1'b0;
            abort    <= 1'b0;
            word_cnt <= '0;
            vmask    <= '0;
          end else begin
            state <= S_IDLE;
          end
        end
        S_CNT: if (wr_en) begin
          if (lo > MAX_CNT) begin
            state <= S_IDLE;
            abort <= 1'b1;
          end else begin
            state  <= S_LOAD;
            remain <= lo[PW-1:0];
          end
        end
        S_LOAD: if (wr_en) begin
          if (!in_page) begin
            state    <= S_IDLE;
            abort    <= 1'b1;
            word_cnt <= '0;
            vmask    <= '0;
          end else begin
            if (first) start_addr <= wr_addr;
            vmask[slot] <= 1'b1;
            word_cnt    <= word_cnt + 1'b1;
            if (remain == '0) state <= S_CONF;
            else              remain <= remain - 1'b1;
          end
        end
        S_CONF: if (wr_en) begin
          if (lo == CONFIRM) begin
            state <= S_PROG;
          end else begin
            state    <= S_IDLE;
            abort    <= 1'b1;
            word_cnt <= '0;
            vmask    <= '0;
          end
        end
        S_PROG: if (prog_ack) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ld_ok) mem[slot] <= wr_data;
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req && !prog_ack |=> prog_req);
  p_ack_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req && prog_ack |=> done && !prog_req && !busy);
  p_req_on_confirm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_req) |-> $past(wr_en) && $past(wr_data[7:0]) == CONFIRM);
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= (PW+1)'(PAGE_WORDS));
  p_abort_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort) |-> word_cnt == '0 && vmask == '0 && !prog_req);
  p_mask_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vmask) <= int'(word_cnt));
  p_busy_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req && $past(prog_req) |-> $stable(word_cnt) && $stable(vmask));
endmodule

// File: tb/wbuf_prog_seq_tb.sv
module wbuf_prog_seq_tb;
  logic        clk = 0, rst_n = 0, bypass_en = 0, wr_en = 0, prog_ack = 0;
  logic [23:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_idx = '0;
  logic        prog_req, busy, done, abort, rd_valid;
  logic [23:0] start_addr;
  logic [5:0]  word_cnt;
  logic [15:0] rd_data;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  wbuf_prog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .prog_ack(prog_ack), .rd_idx(rd_idx),
    .prog_req(prog_req), .busy(busy), .done(done), .abort(abort),
    .start_addr(start_addr), .word_cnt(word_cnt), .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [23:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  task automatic idle1();
    @(negedge clk); wr_en = 0;
  endtask

  task automatic unlock_cmd(input logic [23:0] pg, input logic [15:0] cnt);
    if (!bypass_en) begin
      bw(24'h7A0555, 16'h33AA);
      bw(24'h012AA, 16'hEE55);
    end
    bw(pg, 16'h9925);
    bw(pg, cnt);
  endtask

  function automatic logic [15:0] dval(input int n, input int i);
    return 16'((n * 16'h0313) ^ (i * 16'h1007) ^ 16'hA5C0);
  endfunction

  task automatic check_empty(input string req);
    for (int s = 0; s < 32; s++) begin
      rd_idx = 5'(s); #1;
      chk(rd_valid == 0, req, rd_valid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !prog_req, "R1 busy/req", {busy, prog_req}, 0);
    chk(!done && !abort, "R1 flags", {done, abort}, 0);
    chk(word_cnt == 0, "R1 word_cnt", word_cnt, 0);
    check_empty("R1 valid");

    // R2 R3 R4 R8 R9 R10 sweep over every word count
    for (int n = 1; n <= 32; n++) begin
      automatic logic [23:0] pg = 24'(n * 37 + 3) << 5;
      automatic int off = (n * 5) % 32;
      bypass_en = (n % 2 == 0);
      unlock_cmd(pg, 16'h5A00 | 16'(n - 1));
      for (int i = 0; i < n; i++) begin
        bw(pg | 24'((off + i) % 32), dval(n, i));
        if (n % 3 == 0) idle1();
      end
      idle1();
      chk(prog_req == 0, "R2 no request before confirm", prog_req, 0);
      chk(busy == 1, "R2 busy while loading", busy, 1);
      chk(word_cnt == 6'(n), "R3 count", word_cnt, n);
      if (n == 1) chk(done == 0, "R11 done cleared by new command", done, 0);
      bw(pg | 24'h00F000, 16'hC329);
      idle1();
      chk(prog_req == 1, bypass_en ? "R9 request in bypass" : "R2 request after confirm", prog_req, 1);
      chk(start_addr == (pg | 24'(off)), "R3 start_addr", start_addr, pg | 24'(off));
      for (int s = 0; s < 32; s++) begin
        automatic int k = (s - off + 32) % 32;
        rd_idx = 5'(s); #1;
        chk(rd_valid == (k < n), "R4 valid", rd_valid, k < n);
        if (k < n) chk(rd_data == dval(n, k), "R4 data", rd_data, dval(n, k));
      end
      bw(pg | 24'(off), 16'hFFFF);
      idle1();
      rd_idx = 5'(off); #1;
      chk(rd_data == dval(n, 0), "R8 write ignored while busy", rd_data, dval(n, 0));
      chk(word_cnt == 6'(n) && prog_req, "R8 held", word_cnt, n);
      @(negedge clk); prog_ack = 1;
      @(negedge clk); prog_ack = 0;
      chk(done && !prog_req && !busy, "R8 done on ack", {done, prog_req, busy}, 4);
    end
    bypass_en = 0;

    // R5 out-of-page address
    unlock_cmd(24'h004000, 16'h0007);
    bw(24'h004003, 16'h1111);
    bw(24'h004004, 16'h2222);
    bw(24'h004020, 16'h3333);
    idle1();
    chk(abort == 1 && !busy, "R5 abort", {abort, busy}, 2);
    chk(word_cnt == 0, "R5 count discarded", word_cnt, 0);
    check_empty("R5 buffer discarded");

    // R6 count too large (0x20), upper byte zero
    unlock_cmd(24'h008000, 16'h0020);
    idle1();
    chk(abort == 1 && !busy, "R6 abort on count 32", {abort, busy}, 2);
    bw(24'h008000, 16'h0029);
    idle1();
    chk(prog_req == 0, "R6 no request", prog_req, 0);

    // R7 excess data word after count
    unlock_cmd(24'h00C000, 16'h0002);
    bw(24'h00C000, 16'h0001);
    bw(24'h00C001, 16'h0002);
    bw(24'h00C002, 16'h0003);
    idle1();
    chk(abort == 0 && word_cnt == 3, "R7 loaded before excess", word_cnt, 3);
    bw(24'h00C003, 16'h1234);
    idle1();
    chk(abort == 1 && !prog_req && !busy, "R7 excess aborts", {abort, prog_req}, 2);
    check_empty("R7 buffer discarded");

    // R10 upper bits ignored in command writes (count 0xFF00 -> one word)
    bypass_en = 1;
    bw(24'hFFF000, 16'h7725);
    idle1();
    chk(abort == 0 && busy, "R11 abort cleared by new command", abort, 0);
    bw(24'h010000, 16'hFF00);
    bw(24'h010005, 16'hBEEF);
    bw(24'h010000, 16'h0029);
    idle1();
    chk(prog_req == 1 && word_cnt == 1, "R10 upper bits ignored", word_cnt, 1);
    rd_idx = 5'd5; #1;
    chk(rd_data == 16'hBEEF, "R10 data upper bits kept", rd_data, 16'hBEEF);
    @(negedge clk); prog_ack = 1;
    @(negedge clk); prog_ack = 0;
    bypass_en = 0;

    // R9 bypass off: a bare command in idle starts nothing
    bw(24'h000000, 16'h0025);
    idle1();
    chk(busy == 0, "R9 command needs unlock", busy, 0);

    // R11 wrong unlock
    bw(24'h000555, 16'h00AA);
    bw(24'h0002AA, 16'h0056);
    bw(24'h000000, 16'h0025);
    bw(24'h000000, 16'h0000);
    bw(24'h000001, 16'h4444);
    bw(24'h000000, 16'h0029);
    idle1();
    chk(!prog_req && !abort && !busy, "R11 bad unlock", {prog_req, abort, busy}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule